// File: doc/BRIEF.md
# Shared-Pin Bit Clock Mode and De-Emphasis Control

This block watches a single input pin that serves two purposes. A converter that receives serial audio can have its bit clock supplied on this pin, or the pin can be tied to a static level that turns a de-emphasis filter on or off. The block decides which of these uses applies. When the pin toggles quickly, it selects the external bit clock. When the pin holds a steady level, it filters that level and produces the de-emphasis control bit.

The shared pin and the frame clock both arrive without a known phase relation to the system clock. Each one is passed through a multi-flop synchronizer before any edge is detected. Rising edges on the pin are counted within each half period of the frame clock. When enough of them land in one half period, the block locks into external bit clock mode. That mode stays set until power-down is asserted.

While the block is in internal mode, the pin level is sampled on every falling edge of the frame clock. The de-emphasis state changes only after the same level has been seen for a run of consecutive samples. A low run turns de-emphasis on and a high run turns it off. The bit clock source select tells the downstream serial receiver which clock to use.

Top module: `shm_pin_mode`

## Requirements
- R1: After reset, and on the cycle after power_down is seen high, ext_mode, deemph_en and bclk_src_sel are all 0 and the rising-edge and level-run counts start again from zero.
- R2: Four low-to-high transitions of shared_pin within one half period of frame_clk (high or low phase) set ext_mode to 1.
- R3: A frame_clk edge of either polarity restarts the rising-edge count. Three rising edges, then a frame_clk edge, then three more rising edges, leave ext_mode at 0.
- R4: Once set, ext_mode stays 1 through any shared_pin or frame_clk activity until power_down is asserted.
- R5: While ext_mode is 1, deemph_en is 0, and shared_pin levels at frame_clk falling edges have no effect on it.
- R6: In internal mode, shared_pin sampled low on 8 consecutive frame_clk falling edges sets deemph_en to 1. After only 7 such samples it is unchanged.
- R7: In internal mode, shared_pin sampled high on 8 consecutive frame_clk falling edges clears deemph_en to 0. After only 7 such samples it is unchanged.
- R8: A sample whose level differs from the previous sample restarts the run at one. For example, 7 low, 1 high, then 7 low samples do not set deemph_en, and one further low sample does.
- R9: bclk_src_sel is 1 when ext_mode is 1 (external bit clock) and 0 in internal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_clk | input | 1 | Frame (left/right) clock, asynchronous to clk |
| shared_pin | input | 1 | Shared pin: external bit clock or de-emphasis level, asynchronous |
| power_down | input | 1 | Synchronous power-down; clears mode and de-emphasis state |
| ext_mode | output | 1 | 1 when external bit clock mode has been detected |
| deemph_en | output | 1 | De-emphasis enable, meaningful in internal mode only |
| bclk_src_sel | output | 1 | Bit clock source select: 1 external, 0 internal |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, an edge threshold of four and a run length of eight. These small counts keep edge-count saturation, the restart at each frame edge and run restarts on a level change within reach of a few thousand random operations. The random mix changes its ratio of pin toggles to frame toggles from one epoch to the next. Some epochs rarely reach four edges in a phase and others reach it quickly, so both internal-mode filtering and the sticky external mode get long stretches of coverage. Occasional power-down pulses bring the block back to internal mode.

// File: rtl/shm_pkg.sv
// Package: shared definitions for the shared-pin mode block.
// Assumes: nothing beyond IEEE 1800-2017.
package shm_pkg;

    // Bit clock source encoding driven on bclk_src_sel.
    typedef enum logic {
        BCLK_INTERNAL = 1'b0,
        BCLK_EXTERNAL = 1'b1
    } bclk_src_t;

    // Index of each signal inside the synchronized bundle.
    localparam int IDX_PIN   = 0;
    localparam int IDX_FRAME = 1;
    localparam int NUM_ASYNC = 2;

endpackage

// File: rtl/shm_sync.sv
// Module: shm_sync
// Multi-stage synchronizer for a bundle of asynchronous single-bit inputs.
// Assumes: each bit is independent (no multi-bit coherency needed) and
// STAGES >= 1. Only rst_n clears the chain; power-down does not.
module shm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // First capture flop of the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[gi] <= '0;
                    else        stage_q[gi] <= async_in;
                end
            end else begin : g_next
                // Later flops settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[gi] <= '0;
                    else        stage_q[gi] <= stage_q[gi-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/shm_edge_det.sv
// Module: shm_edge_det
// Produces one-cycle rise and fall pulses for each bit of a synchronized bundle.
// Assumes: inputs are already in the clk domain.
module shm_edge_det #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] prev_q;

    // Keep the previous level so transitions can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    // Edge pulses compare the current level with the stored one.
    always_comb begin
        rise = level & ~prev_q;
        fall = ~level & prev_q;
    end

endmodule

// File: rtl/shm_clk_detect.sv
// Module: shm_clk_detect
// Counts shared-pin rising edges inside each frame clock half period. When
// THRESH edges land in one half period, it sets a sticky external-clock flag.
// Assumes: pulses are single-cycle in the clk domain; clear is a synchronous
// power-down that also removes the sticky flag.
module shm_clk_detect #(
    parameter int THRESH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic pin_rise,
    input  logic frame_edge,
    output logic ext_set,
    output logic ext_mode
);

    localparam int CW = $clog2(THRESH + 1);
    localparam logic [CW-1:0] LAST = CW'(THRESH - 1);
    localparam logic [CW-1:0] FULL = CW'(THRESH);

    logic [CW-1:0] cnt_q;
    logic          ext_q;

    // The flag sets when the edge that completes the threshold arrives.
    always_comb begin
        ext_set = !clear && !ext_q && pin_rise && !frame_edge && (cnt_q == LAST);
    end

    // Rising-edge count per phase; it saturates and restarts on frame edges.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (frame_edge) begin
            cnt_q <= pin_rise ? CW'(1) : '0;
        end else if (pin_rise && cnt_q != FULL) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // Sticky mode flag; only power-down or reset removes it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) ext_q <= 1'b0;
        else if (ext_set)    ext_q <= 1'b1;
    end

    assign ext_mode = ext_q;

    a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);
    a_r2_ext_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_q) |-> $past(pin_rise));
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ext_q && !clear |=> ext_q);
    a_r1_clear_mode: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !ext_q && cnt_q == '0);

endmodule

// File: rtl/shm_level_filter.sv
// Module: shm_level_filter
// Samples the pin level on each strobe (a frame clock falling edge). After
// RUN_LEN equal samples in a row, it sets the output to the inverse of that
// level: a low run turns the control on and a high run turns it off.
// Assumes: strobe is a single-cycle pulse; clear holds the filter idle
// (power-down or external mode).
module shm_level_filter #(
    parameter int RUN_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic strobe,
    input  logic level,
    output logic enable
);

    localparam int RW = $clog2(RUN_LEN + 1);
    localparam logic [RW-1:0] RUN_FULL = RW'(RUN_LEN);

    logic [RW-1:0] run_q;
    logic [RW-1:0] run_next;
    logic          last_q;
    logic          have_q;
    logic          en_q;

    // Next run length: extend it on a repeated level, restart it otherwise.
    always_comb begin
        if (have_q && level == last_q)
            run_next = (run_q == RUN_FULL) ? RUN_FULL : run_q + RW'(1);
        else
            run_next = RW'(1);
    end

    // Run tracking state, updated only on strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_q  <= '0;
            last_q <= 1'b0;
            have_q <= 1'b0;
        end else if (strobe) begin
            run_q  <= run_next;
            last_q <= level;
            have_q <= 1'b1;
        end
    end

    // Output register, changed only when a full run completes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            en_q <= 1'b0;
        else if (strobe && run_next == RUN_FULL)
            en_q <= ~level;
    end

    assign enable = en_q;

    a_r6_change_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_q) && !$past(clear) |-> $past(strobe));
    a_r8_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_FULL);
    a_r5_off_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !en_q);

endmodule

// File: rtl/shm_pin_mode.sv
// Module: shm_pin_mode (top)
// Classifies a shared pin either as an external bit clock (sticky mode) or
// as a de-emphasis control level that is filtered over frame clock falling
// edges.
// Assumes: frame_clk and shared_pin are asynchronous and slower than clk/2,
// so each transition is seen once after synchronization. power_down is
// synchronous to clk.
module shm_pin_mode
    import shm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int EDGE_THRESH = 4,
    parameter int RUN_LEN     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_clk,
    input  logic shared_pin,
    input  logic power_down,
    output logic ext_mode,
    output logic deemph_en,
    output logic bclk_src_sel
);

    logic [NUM_ASYNC-1:0] raw_bus;
    logic [NUM_ASYNC-1:0] sync_bus;
    logic [NUM_ASYNC-1:0] rise_bus;
    logic [NUM_ASYNC-1:0] fall_bus;
    logic                 ext_set;
    logic                 ext_q;
    logic                 filt_clear;
    logic                 filt_en;
    bclk_src_t            src;

    // Gather the asynchronous inputs into one bundle.
    always_comb begin
        raw_bus            = '0;
        raw_bus[IDX_PIN]   = shared_pin;
        raw_bus[IDX_FRAME] = frame_clk;
    end

    shm_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_bus),
        .sync_out (sync_bus)
    );

    shm_edge_det #(.WIDTH(NUM_ASYNC)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sync_bus),
        .rise  (rise_bus),
        .fall  (fall_bus)
    );

    shm_clk_detect #(.THRESH(EDGE_THRESH)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (power_down),
        .pin_rise   (rise_bus[IDX_PIN]),
        .frame_edge (rise_bus[IDX_FRAME] | fall_bus[IDX_FRAME]),
        .ext_set    (ext_set),
        .ext_mode   (ext_q)
    );

    // The level filter is idle in power-down and in external mode, including
    // the cycle in which external mode is being entered.
    always_comb begin
        filt_clear = power_down | ext_q | ext_set;
    end

    shm_level_filter #(.RUN_LEN(RUN_LEN)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (filt_clear),
        .strobe (fall_bus[IDX_FRAME]),
        .level  (sync_bus[IDX_PIN]),
        .enable (filt_en)
    );

    // Map the mode flag onto the bit clock source encoding.
    always_comb begin
        src = ext_q ? BCLK_EXTERNAL : BCLK_INTERNAL;
    end

    assign ext_mode     = ext_q;
    assign deemph_en    = filt_en;
    assign bclk_src_sel = src;

    a_r5_no_deemph_in_ext: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |-> !deemph_en);
    a_r1_pd_clears_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> !ext_mode && !deemph_en && !bclk_src_sel);
    a_r4_ext_held: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode && !power_down |=> ext_mode && bclk_src_sel);

endmodule

// File: tb/tb_shm_pin_mode.sv
module tb_shm_pin_mode;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_clk = 1'b0;
    logic shared_pin = 1'b0;
    logic power_down = 1'b0;
    logic ext_mode, deemph_en, bclk_src_sel;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference model state
    bit m_ext = 1'b0;
    bit m_deemph = 1'b0;
    int m_rises = 0;
    int m_run = 0;
    bit m_last = 1'b0;
    bit m_have = 1'b0;

    always #10 clk = ~clk;

    shm_pin_mode dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_clk    (frame_clk),
        .shared_pin   (shared_pin),
        .power_down   (power_down),
        .ext_mode     (ext_mode),
        .deemph_en    (deemph_en),
        .bclk_src_sel (bclk_src_sel)
    );

    function automatic int next_run(int run, bit have, bit last, bit lvl);
        if (have && lvl == last) return (run >= 8) ? 8 : run + 1;
        return 1;
    endfunction

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic check(string req);
        n_vec++;
        if (ext_mode !== m_ext || deemph_en !== m_deemph || bclk_src_sel !== m_ext) begin
            n_bad++;
            $display("FAIL %s: actual ext=%b deemph=%b sel=%b expected ext=%b deemph=%b sel=%b",
                     req, ext_mode, deemph_en, bclk_src_sel, m_ext, m_deemph, m_ext);
        end
    endtask

    task automatic model_clear();
        m_ext = 0; m_deemph = 0; m_rises = 0; m_run = 0; m_last = 0; m_have = 0;
    endtask

    task automatic set_pin(bit v);
        if (v && !shared_pin) begin
            if (m_rises < 4) m_rises++;
            if (m_rises == 4 && !m_ext) begin
                m_ext = 1; m_deemph = 0; m_run = 0; m_have = 0; m_last = 0;
            end
        end
        shared_pin = v;
        settle();
    endtask

    task automatic toggle_frame();
        bit nf;
        nf = ~frame_clk;
        m_rises = 0;
        if (!nf && !m_ext) begin
            m_run = next_run(m_run, m_have, m_last, shared_pin);
            m_last = shared_pin;
            m_have = 1;
            if (m_run == 8) m_deemph = ~shared_pin;
        end
        frame_clk = nf;
        settle();
    endtask

    task automatic falls(int n);
        for (int i = 0; i < n; i++) begin
            if (frame_clk) toggle_frame();
            else begin toggle_frame(); toggle_frame(); end
        end
    endtask

    task automatic pulse_pd();
        power_down = 1;
        repeat (4) @(negedge clk);
        model_clear();
        power_down = 0;
        settle();
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int unsigned seed_dummy;
        int pin_w;
        seed_dummy = $urandom(32'h1234_5678);
        repeat (5) @(negedge clk);
        rst_n = 1;
        settle();
        check("R1 reset");

        // R3: three rises, frame edge, three rises -> still internal
        for (int i = 0; i < 3; i++) begin set_pin(1); set_pin(0); end
        toggle_frame();
        for (int i = 0; i < 3; i++) begin set_pin(1); set_pin(0); end
        check("R3 count restarts on frame edge");
        toggle_frame();

        // R2 / R9: four rises in one phase
        for (int i = 0; i < 4; i++) begin set_pin(1); set_pin(0); end
        check("R2 four rises enter external, R9 sel");

        // R4 / R5: sticky, no de-emphasis even with 10 low falls
        falls(10);
        for (int i = 0; i < 3; i++) begin set_pin(1); set_pin(0); toggle_frame(); end
        check("R4 sticky external");
        check("R5 no deemph in external");

        pulse_pd();
        check("R1 power-down returns internal");

        // R6: low run
        set_pin(0);
        falls(7);
        check("R6 seven low falls not enough");
        falls(1);
        check("R6 eight low falls enable");

        // R8 then R7: high run with break
        set_pin(1);
        falls(7);
        set_pin(0);
        falls(1);
        set_pin(1);
        falls(7);
        check("R8 break restarts high run");
        falls(1);
        check("R7 eight high falls disable");

        set_pin(0);
        falls(7);
        set_pin(1);
        falls(1);
        set_pin(0);
        falls(7);
        check("R8 break restarts low run");
        falls(1);
        check("R8 full low run after restart");

        // Random mix across epochs of different pin-toggle density
        pin_w = 50;
        for (int i = 0; i < 1800; i++) begin
            int r;
            if (i % 150 == 0) pin_w = 20 + 30 * int'($urandom_range(0, 2));
            r = int'($urandom_range(0, 99));
            if (r < pin_w) set_pin(~shared_pin);
            else if (r < 98) toggle_frame();
            else pulse_pd();
            check("R2/R3/R4/R5/R6/R7/R8/R9 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule